// File: doc/BRIEF.md
# USB OTG Endpoint and Core Interrupt Combiner

This block collects event pulses from a USB OTG controller into two interrupt groups and drives one level interrupt line to a processor. The endpoint group holds one bit per transmit endpoint (0 to 15) and one per receive endpoint (1 to 15). The core group holds a nine-bit field of controller events. The top field bit reports a change in the VBUS drive request.

Each group has a raw source register and a mask register. Neither is written directly. Software changes them through write-one-to-set and write-one-to-clear aliases. Software reads the AND of the two through a masked view. Writing to a source-set alias forces an event, so software can raise an interrupt for test.

Once the line rises, it stays high until software writes the end-of-interrupt register. That write drops the line. The line rises again on the next cycle if masked sources are still pending. A self-clearing soft-reset bit clears every source and mask bit.

Top module: `otg_irq_combiner`

## Requirements
- R1: After reset, all source and mask bits are zero, `irq` is low, and offset 0x00 reads the fixed nonzero constant `REV_ID` (default 0x00000A35).
- R2: A pulse on `ep_evt[b]` sets bit b of the endpoint source (offset 0x20) on the next clock edge. Bits 15:0 are transmit endpoints 0 to 15, and bits 31:17 are receive endpoints 1 to 15. Bit 16 always reads zero, whatever the events or writes.
- R3: A pulse on `core_evt[i]` sets bit 16+i of the core source (offset 0x40). Core bits outside 24:16 always read zero. Bit 24 is the VBUS drive-request change event.
- R4: Writing ones to the source-set alias (0x24 endpoint, 0x44 core) sets those source bits. Writing ones to the source-clear alias (0x28, 0x48) clears them. Zero bits in the written value leave their bits unchanged.
- R5: Writing ones to the mask-set alias (0x30, 0x50) sets those mask bits, and writing ones to the mask-clear alias (0x34, 0x54) clears them. The masks read back at 0x2C and 0x4C.
- R6: The masked views at 0x38 and 0x58 read the source of their group ANDed with its mask.
- R7: `irq` rises one cycle after a masked source becomes nonzero. It then stays high until an end-of-interrupt write, even if every source is cleared.
- R8: Any write to offset 0x60 drops `irq` at that edge. If masked sources are still pending, `irq` rises again at the next edge. Otherwise it stays low.
- R9: If an event pulse and a source-clear write hit the same bit in the same cycle, the bit ends up set. Other bits named in the clear are cleared.
- R10: Writing 1 to bit 0 of the control register (0x04) clears all sources, all masks and `irq` at that edge. The control register always reads zero.
- R11: Undefined offsets read zero, and writes to them have no effect. Writes to the raw source (0x20, 0x40), mask (0x2C, 0x4C) and masked-view offsets have no effect. Set/clear aliases and end-of-interrupt read zero.
- R12: The status register (0x08) reads bit 0 = endpoint masked source nonzero and bit 1 = core masked source nonzero. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ep_evt | input | 32 | Endpoint event pulses, one per source bit |
| core_evt | input | CORE_W | Core event pulses |
| irq | output | 1 | Level interrupt to the processor |

## Verification
A write or event pulse updates registers at the clock edge where it is sampled, and reads are combinational. The bench therefore checks register contents at the falling edge right after that clock edge.

`irq` is registered from the pending state, so it rises one edge after a masked source appears. The bench checks it low at the first falling edge and high at the second. An end-of-interrupt write drops `irq` at its own edge. With sources still pending, the line returns one edge later, and the bench samples both of those falling edges.

// File: rtl/otg_irq_combiner.sv
module otg_irq_combiner #(
  parameter int          ADDR_W   = 8,
  parameter int          CORE_W   = 9,
  parameter int          CORE_LSB = 16,
  parameter logic [31:0] REV_ID   = 32'h0000_0A35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       ep_evt,
  input  logic [CORE_W-1:0] core_evt,
  output logic              irq
);
  localparam logic [31:0] EP_VALID = 32'hFFFE_FFFF;
  localparam logic [ADDR_W-1:0] A_REV = 'h00, A_CTRL = 'h04, A_STAT = 'h08,
    A_EP_SRC = 'h20, A_EP_SET = 'h24, A_EP_CLR = 'h28, A_EP_MSK = 'h2C,
    A_EP_MSET = 'h30, A_EP_MCLR = 'h34, A_EP_MVIEW = 'h38,
    A_CO_SRC = 'h40, A_CO_SET = 'h44, A_CO_CLR = 'h48, A_CO_MSK = 'h4C,
    A_CO_MSET = 'h50, A_CO_MCLR = 'h54, A_CO_MVIEW = 'h58, A_EOI = 'h60;

  logic [31:0]       ep_src, ep_msk;
  logic [CORE_W-1:0] core_src, core_msk;
  logic              irq_q;

  wire [CORE_W-1:0] wfield = bus_wdata[CORE_LSB +: CORE_W];
  wire soft_rst = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
  wire eoi      = bus_wr && bus_addr == A_EOI;

  wire [31:0] ep_set  = (bus_wr && bus_addr == A_EP_SET)  ? bus_wdata : '0;
  wire [31:0] ep_clr  = (bus_wr && bus_addr == A_EP_CLR)  ? bus_wdata : '0;
  wire [31:0] ep_mset = (bus_wr && bus_addr == A_EP_MSET) ? bus_wdata : '0;
  wire [31:0] ep_mclr = (bus_wr && bus_addr == A_EP_MCLR) ? bus_wdata : '0;
  wire [CORE_W-1:0] co_set  = (bus_wr && bus_addr == A_CO_SET)  ? wfield : '0;
  wire [CORE_W-1:0] co_clr  = (bus_wr && bus_addr == A_CO_CLR)  ? wfield : '0;
  wire [CORE_W-1:0] co_mset = (bus_wr && bus_addr == A_CO_MSET) ? wfield : '0;
  wire [CORE_W-1:0] co_mclr = (bus_wr && bus_addr == A_CO_MCLR) ? wfield : '0;

  wire [31:0]       ep_pend   = ep_src & ep_msk;
  wire [CORE_W-1:0] core_pend = core_src & core_msk;
  wire              pend_any  = |ep_pend || |core_pend;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ep_src   <= '0;
      ep_msk   <= '0;
      core_src <= '0;
      core_msk <= '0;
      irq_q    <= 1'b0;
    end else begin
      ep_src   <= ((ep_src & ~ep_clr) | ep_set | ep_evt) & EP_VALID;
      ep_msk   <= ((ep_msk & ~ep_mclr) | ep_mset) & EP_VALID;
      core_src <= (core_src & ~co_clr) | co_set | core_evt;
      core_msk <= (core_msk & ~co_mclr) | co_mset;
      irq_q    <= eoi ? 1'b0 : (irq_q | pend_any);
    end
  end

  assign irq = irq_q;

  always_comb begin
    case (bus_addr)
      A_REV:      bus_rdata = REV_ID;
      A_STAT:     bus_rdata = {30'b0, |core_pend, |ep_pend};
      A_EP_SRC:   bus_rdata = ep_src;
      A_EP_MSK:   bus_rdata = ep_msk;
      A_EP_MVIEW: bus_rdata = ep_pend;
      A_CO_SRC:   bus_rdata = 32'(core_src) << CORE_LSB;
      A_CO_MSK:   bus_rdata = 32'(core_msk) << CORE_LSB;
      A_CO_MVIEW: bus_rdata = 32'(core_pend) << CORE_LSB;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/otg_irq_combiner_chk.sv
module otg_irq_combiner_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       ep_evt,
  input logic [31:0]       ep_src,
  input logic              pend_any,
  input logic              irq
);
  wire eoi  = bus_wr && bus_addr == ADDR_W'(8'h60);
  wire srst = bus_wr && bus_addr == ADDR_W'(8'h04) && bus_wdata[0];
  wire [31:0] evt_v = ep_evt & 32'hFFFE_FFFF;

  a_r8_eoi_drops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq);
  a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi && !srst) |=> irq);
  a_r7_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any && !eoi && !srst) |=> irq);
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_v && !srst) |=> ((ep_src & $past(evt_v)) == $past(evt_v)));
  a_r2_rx0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h20)) |-> !bus_rdata[16]);
  a_r11_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(8'h10)) |-> bus_rdata == 32'h0);
endmodule

bind otg_irq_combiner otg_irq_combiner_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ep_evt(ep_evt),
  .ep_src(ep_src), .pend_any(pend_any), .irq(irq));

// File: tb/otg_irq_combiner_tb.sv
module otg_irq_combiner_tb;
  localparam int PERIOD = 10;
  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 8'hFC;
  logic [31:0] bus_wdata = 0, bus_rdata, ep_evt = 0;
  logic [8:0]  core_evt = 0;
  logic        irq;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  otg_irq_combiner u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ep_evt(ep_evt), .core_evt(core_evt), .irq(irq));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; #1; check(bus_rdata, exp, req); bus_addr = 8'hFC;
  endtask

  task automatic cleanup;
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h60, 32'h0); @(negedge clk);
  endtask

  task automatic t_reset;
    check({31'b0, irq}, 0, "R1 irq");
    rd(8'h00, 32'h0000_0A35, "R1 revision");
    rd(8'h20, 0, "R1 ep src"); rd(8'h4C, 0, "R1 core mask");
  endtask

  task automatic t_ep_events;
    @(negedge clk); ep_evt = 32'h8003_0005;
    @(negedge clk); ep_evt = 0;
    rd(8'h20, 32'h8002_0005, "R2 ep events, bit16 dropped");
    wr(8'h24, 32'h0001_0000);
    rd(8'h20, 32'h8002_0005, "R2 set of bit16 ignored");
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R4 ep clear all");
  endtask

  task automatic t_core;
    @(negedge clk); core_evt = 9'h1FF;
    @(negedge clk); core_evt = 0;
    rd(8'h40, 32'h01FF_0000, "R3 core events");
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, 32'h01FF_0000, "R3 core set outside field");
    wr(8'h48, 32'h0100_0000);
    rd(8'h40, 32'h00FF_0000, "R4 core partial clear");
    cleanup;
  endtask

  task automatic t_masks;
    wr(8'h30, 32'h0000_00F0); wr(8'h34, 32'h0000_0030);
    rd(8'h2C, 32'h0000_00C0, "R5 ep mask set/clear");
    wr(8'h24, 32'h0000_0050);
    rd(8'h20, 32'h0000_0050, "R4 ep set alias");
    rd(8'h38, 32'h0000_0040, "R6 ep masked view");
    rd(8'h08, 32'h1, "R12 status ep pending");
    cleanup;
    wr(8'h50, 32'h0180_0000); wr(8'h44, 32'h0100_0000);
    rd(8'h58, 32'h0100_0000, "R6 core masked view");
    rd(8'h08, 32'h2, "R12 status core pending");
    cleanup;
  endtask

  task automatic t_line;
    check({31'b0, irq}, 0, "R8 line low after cleanup");
    wr(8'h50, 32'h0100_0000);
    @(negedge clk); core_evt = 9'h100;
    @(negedge clk); core_evt = 0;
    check({31'b0, irq}, 0, "R7 not yet raised");
    @(negedge clk);
    check({31'b0, irq}, 1, "R7 raised");
    wr(8'h48, 32'h0100_0000);
    @(negedge clk);
    check({31'b0, irq}, 1, "R7 held after source clear");
    wr(8'h60, 32'h1234);
    check({31'b0, irq}, 0, "R8 dropped by eoi");
    @(negedge clk);
    check({31'b0, irq}, 0, "R8 stays low with no pending");
    wr(8'h44, 32'h0100_0000);
    check({31'b0, irq}, 0, "R7 forced event one cycle later");
    @(negedge clk);
    check({31'b0, irq}, 1, "R7 forced event raises line");
    wr(8'h60, 32'h0);
    check({31'b0, irq}, 0, "R8 low cycle after eoi");
    @(negedge clk);
    check({31'b0, irq}, 1, "R8 re-raised while pending");
    cleanup;
  endtask

  task automatic t_event_wins;
    wr(8'h24, 32'h0000_0028);
    @(negedge clk); ep_evt = 32'h8; bus_addr = 8'h28; bus_wdata = 32'h28; bus_wr = 1;
    @(negedge clk); ep_evt = 0; bus_wr = 0;
    rd(8'h20, 32'h0000_0008, "R9 event beats clear");
    cleanup;
  endtask

  task automatic t_soft_reset;
    wr(8'h30, 32'hFF); wr(8'h50, 32'h01FF_0000);
    wr(8'h24, 32'h0F); wr(8'h44, 32'h0003_0000);
    @(negedge clk);
    check({31'b0, irq}, 1, "R10 line up before soft reset");
    wr(8'h04, 32'h1);
    check({31'b0, irq}, 0, "R10 line cleared");
    rd(8'h20, 0, "R10 ep src cleared"); rd(8'h40, 0, "R10 core src cleared");
    rd(8'h2C, 0, "R10 ep mask cleared"); rd(8'h4C, 0, "R10 core mask cleared");
    rd(8'h04, 0, "R10 control reads zero");
  endtask

  task automatic t_undef;
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF); wr(8'h38, 32'hFFFF_FFFF); wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h20, 0, "R11 raw ep src not writable");
    rd(8'h40, 0, "R11 raw core src not writable");
    rd(8'h2C, 0, "R11 mask not directly writable");
    rd(8'h10, 0, "R11 undefined reads zero");
    rd(8'h24, 0, "R11 set alias reads zero");
    rd(8'h60, 0, "R11 eoi reads zero");
    check({31'b0, irq}, 0, "R11 line unaffected");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_ep_events; t_core; t_masks; t_line; t_event_wins; t_soft_reset; t_undef;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule